// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle 16-bit processor core. It is a Moore state machine that takes each instruction through a fetch step, a decode step and then a short path of execute, memory and write-back steps. The path depends on the 4-bit operation code held in the instruction register. Every step drives one fixed set of datapath enables and multiplexer selects. The one exception is the ALU function during execute, which comes from the low opcode bits. The register file, the ALU, memory and the instruction and program-counter registers are outside the block. The branch decision (conditional PC load AND ALU zero) is also made outside.

The opcode input must stay stable from the decode step until the instruction returns to fetch. The datapath meets this by loading the instruction register only while `ir_load` is high. A reset returns the sequencer to fetch. A halt instruction parks it until the next reset.

Top module: `mcyc_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the outputs form the fetch word: `ir_load`=1, `pc_load`=1, `alu_b_sel`=01, `pc_next_sel`=00, and every other output 0. A reset asserted mid-instruction returns the sequencer to fetch at the next edge.
- R2: Fetch is always followed by one decode cycle: `alu_b_sel`=10 and every other output 0.
- R3: Load (opcode 0110) runs decode, then an address step (`alu_a_sel`=1, `alu_b_sel`=10, `alu_fn`=000), a read step (`mem_addr_sel`=1), and a write-back step (`rf_we`=1, `wb_from_mem`=1, `wr_dst_rd`=0). It then returns to fetch.
- R4: Store (0111) runs decode, the same address step, and a write step (`mem_addr_sel`=1, `mem_we`=1). It then returns to fetch.
- R5: Register-register operations (0000 to 0101, and 1110 set-on-less-than) run an execute step with `alu_a_sel`=1, `alu_b_sel`=00 and `alu_fn`=opcode[2:0]. A completion step follows with `wr_dst_rd`=1 and `rf_we`=1. Then fetch.
- R6: Immediate operations (1000 to 1010) run an execute step with `alu_a_sel`=1, `alu_b_sel`=10 and `alu_fn`=opcode[2:0]. A completion step follows with `rf_we`=1, `wr_dst_rd`=0 and `wb_from_mem`=0. Then fetch.
- R7: Branch-if-equal (1011) runs one step with `alu_a_sel`=1, `alu_b_sel`=00, `alu_fn`=011 (subtract), `pc_load_if_zero`=1 and `pc_next_sel`=01. Then fetch.
- R8: Jump (1101) runs one step with `pc_load`=1 and `pc_next_sel`=10. Then fetch.
- R9: Jump-and-link (1111) first runs a link step with `rf_we`=1 and `link_we`=1, which writes the return address to register 15. It then runs the jump step of R8, then fetch.
- R10: Halt (1100) enters a stop state after decode. In that state all outputs are 0 and it stays there whatever the opcode does, until reset.
- R11: At most one of `ir_load`, `mem_we` and `rf_we` is high in any cycle. Outputs not named for a step are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Operation code from the instruction register |
| wr_dst_rd | output | 1 | Register write address from the rd field (1) or the rt field (0) |
| rf_we | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | ALU A operand: register (1) or PC (0) |
| alu_b_sel | output | 2 | ALU B operand: 00 register, 01 constant four, 10 sign-extended immediate |
| alu_fn | output | 3 | ALU function code |
| mem_we | output | 1 | Memory write enable |
| wb_from_mem | output | 1 | Register write data from the memory data register |
| mem_addr_sel | output | 1 | Memory address from the ALU result (1) or the PC (0) |
| ir_load | output | 1 | Instruction register load |
| pc_load | output | 1 | Unconditional PC load |
| pc_load_if_zero | output | 1 | PC load qualified outside by ALU zero |
| pc_next_sel | output | 2 | PC source: 00 ALU, 01 branch target, 10 jump address |
| link_we | output | 1 | Write PC to register 15 |

## Verification
A wrong internal state shows at the ports in the next cycle as an output word that does not belong to the expected step. The bench compares the full output word on every cycle of every instruction path. A missed return to fetch shows as `ir_load` staying low one cycle after the last step. A wrong decode branch shows within two cycles of fetch as the wrong execute or address word. A halt that leaks shows as any nonzero output while parked.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int OPC_W   = 4;
    localparam int ALUFN_W = 3;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_ADDR,
        ST_MEMRD,
        ST_LDWB,
        ST_MEMWR,
        ST_REXEC,
        ST_RDONE,
        ST_BRANCH,
        ST_JUMP,
        ST_IEXEC,
        ST_IDONE,
        ST_LINK,
        ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        K_ARITH,
        K_IMM,
        K_LOAD,
        K_STORE,
        K_BRANCH,
        K_JUMP,
        K_CALL,
        K_STOP
    } kind_e;

    localparam logic [ALUFN_W-1:0] FN_ADD = 3'b000;
    localparam logic [ALUFN_W-1:0] FN_SUB = 3'b011;

    localparam logic [1:0] BSEL_REG  = 2'b00;
    localparam logic [1:0] BSEL_FOUR = 2'b01;
    localparam logic [1:0] BSEL_IMM  = 2'b10;

    localparam logic [1:0] PCSEL_ALU = 2'b00;
    localparam logic [1:0] PCSEL_TGT = 2'b01;
    localparam logic [1:0] PCSEL_JMP = 2'b10;

    typedef struct packed {
        logic               wr_dst_rd;
        logic               rf_we;
        logic               alu_a_sel;
        logic [1:0]         alu_b_sel;
        logic [ALUFN_W-1:0] alu_fn;
        logic               mem_we;
        logic               wb_from_mem;
        logic               mem_addr_sel;
        logic               ir_load;
        logic               pc_load;
        logic               pc_load_if_zero;
        logic [1:0]         pc_next_sel;
        logic               link_we;
    } ctrl_t;

    // Sort an operation code into the path it takes after decode.
    function automatic kind_e classify(input logic [OPC_W-1:0] op);
        kind_e k;
        unique case (op)
            4'b0000, 4'b0001, 4'b0010,
            4'b0011, 4'b0100, 4'b0101,
            4'b1110:                   k = K_ARITH;
            4'b1000, 4'b1001, 4'b1010: k = K_IMM;
            4'b0110:                   k = K_LOAD;
            4'b0111:                   k = K_STORE;
            4'b1011:                   k = K_BRANCH;
            4'b1100:                   k = K_STOP;
            4'b1101:                   k = K_JUMP;
            default:                   k = K_CALL;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/mcyc_op_class.sv
module mcyc_op_class
    import mcyc_pkg::*;
#(
    parameter int OP_W = OPC_W
) (
    input  logic [OP_W-1:0] opcode_i,
    output kind_e           kind_o
);
    always_comb begin
        kind_o = classify(opcode_i);
    end
endmodule

// File: rtl/mcyc_next_state.sv
module mcyc_next_state
    import mcyc_pkg::*;
(
    input  state_e state_i,
    input  kind_e  kind_i,
    output state_e nxt_o
);
    always_comb begin
        nxt_o = ST_FETCH;
        unique case (state_i)
            ST_FETCH:  nxt_o = ST_DECODE;
            ST_DECODE: begin
                unique case (kind_i)
                    K_LOAD, K_STORE: nxt_o = ST_ADDR;
                    K_ARITH:         nxt_o = ST_REXEC;
                    K_IMM:           nxt_o = ST_IEXEC;
                    K_BRANCH:        nxt_o = ST_BRANCH;
                    K_JUMP:          nxt_o = ST_JUMP;
                    K_CALL:          nxt_o = ST_LINK;
                    default:         nxt_o = ST_HALT;
                endcase
            end
            ST_ADDR:   nxt_o = (kind_i == K_LOAD) ? ST_MEMRD : ST_MEMWR;
            ST_MEMRD:  nxt_o = ST_LDWB;
            ST_REXEC:  nxt_o = ST_RDONE;
            ST_IEXEC:  nxt_o = ST_IDONE;
            ST_LINK:   nxt_o = ST_JUMP;
            ST_HALT:   nxt_o = ST_HALT;
            default:   nxt_o = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcyc_state_reg.sv
module mcyc_state_reg
    import mcyc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_e nxt_i,
    output state_e state_o
);
    always_ff @(posedge clk) begin
        if (rst) state_o <= ST_FETCH;
        else     state_o <= nxt_i;
    end

    // The stop state is left only through reset.
    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_HALT) |=> (state_o == ST_HALT));

    assert_reset_lands_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_o == ST_FETCH));
endmodule

// File: rtl/mcyc_out_decode.sv
module mcyc_out_decode
    import mcyc_pkg::*;
#(
    parameter int FN_W = ALUFN_W
) (
    input  state_e          state_i,
    input  logic [FN_W-1:0] fn_bits_i,
    output ctrl_t           ctrl_o
);
    always_comb begin
        ctrl_o = '0;
        unique case (state_i)
            ST_FETCH: begin
                ctrl_o.alu_b_sel   = BSEL_FOUR;
                ctrl_o.alu_fn      = FN_ADD;
                ctrl_o.ir_load     = 1'b1;
                ctrl_o.pc_load     = 1'b1;
                ctrl_o.pc_next_sel = PCSEL_ALU;
            end
            ST_DECODE: begin
                ctrl_o.alu_b_sel = BSEL_IMM;
                ctrl_o.alu_fn    = FN_ADD;
            end
            ST_ADDR: begin
                ctrl_o.alu_a_sel = 1'b1;
                ctrl_o.alu_b_sel = BSEL_IMM;
                ctrl_o.alu_fn    = FN_ADD;
            end
            ST_MEMRD: ctrl_o.mem_addr_sel = 1'b1;
            ST_LDWB: begin
                ctrl_o.rf_we       = 1'b1;
                ctrl_o.wb_from_mem = 1'b1;
            end
            ST_MEMWR: begin
                ctrl_o.mem_addr_sel = 1'b1;
                ctrl_o.mem_we       = 1'b1;
            end
            ST_REXEC: begin
                ctrl_o.alu_a_sel = 1'b1;
                ctrl_o.alu_b_sel = BSEL_REG;
                ctrl_o.alu_fn    = fn_bits_i;
            end
            ST_RDONE: begin
                ctrl_o.wr_dst_rd = 1'b1;
                ctrl_o.rf_we     = 1'b1;
            end
            ST_IEXEC: begin
                ctrl_o.alu_a_sel = 1'b1;
                ctrl_o.alu_b_sel = BSEL_IMM;
                ctrl_o.alu_fn    = fn_bits_i;
            end
            ST_IDONE: ctrl_o.rf_we = 1'b1;
            ST_BRANCH: begin
                ctrl_o.alu_a_sel       = 1'b1;
                ctrl_o.alu_b_sel       = BSEL_REG;
                ctrl_o.alu_fn          = FN_SUB;
                ctrl_o.pc_load_if_zero = 1'b1;
                ctrl_o.pc_next_sel     = PCSEL_TGT;
            end
            ST_JUMP: begin
                ctrl_o.pc_load     = 1'b1;
                ctrl_o.pc_next_sel = PCSEL_JMP;
            end
            ST_LINK: begin
                ctrl_o.rf_we   = 1'b1;
                ctrl_o.link_we = 1'b1;
            end
            default: ctrl_o = '0;
        endcase
    end
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcyc_pkg::*;
#(
    parameter int OP_W = OPC_W,
    parameter int FN_W = ALUFN_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output logic            wr_dst_rd,
    output logic            rf_we,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [FN_W-1:0] alu_fn,
    output logic            mem_we,
    output logic            wb_from_mem,
    output logic            mem_addr_sel,
    output logic            ir_load,
    output logic            pc_load,
    output logic            pc_load_if_zero,
    output logic [1:0]      pc_next_sel,
    output logic            link_we
);
    state_e state_q;
    state_e state_d;
    kind_e  kind;
    ctrl_t  ctrl;

    mcyc_op_class #(.OP_W(OP_W)) u_class (
        .opcode_i (opcode),
        .kind_o   (kind)
    );

    mcyc_next_state u_next (
        .state_i (state_q),
        .kind_i  (kind),
        .nxt_o   (state_d)
    );

    mcyc_state_reg u_state (
        .clk     (clk),
        .rst     (rst),
        .nxt_i   (state_d),
        .state_o (state_q)
    );

    mcyc_out_decode #(.FN_W(FN_W)) u_out (
        .state_i   (state_q),
        .fn_bits_i (opcode[FN_W-1:0]),
        .ctrl_o    (ctrl)
    );

    assign wr_dst_rd       = ctrl.wr_dst_rd;
    assign rf_we           = ctrl.rf_we;
    assign alu_a_sel       = ctrl.alu_a_sel;
    assign alu_b_sel       = ctrl.alu_b_sel;
    assign alu_fn          = ctrl.alu_fn;
    assign mem_we          = ctrl.mem_we;
    assign wb_from_mem     = ctrl.wb_from_mem;
    assign mem_addr_sel    = ctrl.mem_addr_sel;
    assign ir_load         = ctrl.ir_load;
    assign pc_load         = ctrl.pc_load;
    assign pc_load_if_zero = ctrl.pc_load_if_zero;
    assign pc_next_sel     = ctrl.pc_next_sel;
    assign link_we         = ctrl.link_we;

    // Port-level sequencing checks.
    assert_decode_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> (!ir_load && !pc_load && !rf_we && !mem_we && !pc_load_if_zero));

    assert_read_then_wb_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_addr_sel && !mem_we) |=> (rf_we && wb_from_mem));

    assert_store_returns_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> ir_load);

    assert_branch_returns_R7: assert property (@(posedge clk) disable iff (rst)
        pc_load_if_zero |=> ir_load);

    assert_link_then_jump_R9: assert property (@(posedge clk) disable iff (rst)
        link_we |=> (pc_load && pc_next_sel == PCSEL_JMP && !ir_load));

    assert_write_excl_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ir_load, mem_we, rf_we}));
endmodule

// File: tb/tb_mcyc_ctrl.sv
module tb_mcyc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    // Step codes of the bench.
    localparam logic [3:0] P_F = 4'd0, P_D = 4'd1, P_A = 4'd2, P_MR = 4'd3,
                           P_LW = 4'd4, P_MW = 4'd5, P_RX = 4'd6, P_RW = 4'd7,
                           P_BR = 4'd8, P_JP = 4'd9, P_IX = 4'd10, P_IW = 4'd11,
                           P_LK = 4'd12, P_H = 4'd13;

    // {opcode, step count, five step codes}
    localparam int NVEC = 15;
    localparam logic [27:0] VEC [NVEC] = '{
        {4'b0000, 4'd4, P_F, P_D, P_RX, P_RW, P_F},
        {4'b0001, 4'd4, P_F, P_D, P_RX, P_RW, P_F},
        {4'b0010, 4'd4, P_F, P_D, P_RX, P_RW, P_F},
        {4'b0011, 4'd4, P_F, P_D, P_RX, P_RW, P_F},
        {4'b0100, 4'd4, P_F, P_D, P_RX, P_RW, P_F},
        {4'b0101, 4'd4, P_F, P_D, P_RX, P_RW, P_F},
        {4'b0110, 4'd5, P_F, P_D, P_A,  P_MR, P_LW},
        {4'b0111, 4'd4, P_F, P_D, P_A,  P_MW, P_F},
        {4'b1000, 4'd4, P_F, P_D, P_IX, P_IW, P_F},
        {4'b1001, 4'd4, P_F, P_D, P_IX, P_IW, P_F},
        {4'b1010, 4'd4, P_F, P_D, P_IX, P_IW, P_F},
        {4'b1011, 4'd3, P_F, P_D, P_BR, P_F,  P_F},
        {4'b1101, 4'd3, P_F, P_D, P_JP, P_F,  P_F},
        {4'b1110, 4'd4, P_F, P_D, P_RX, P_RW, P_F},
        {4'b1111, 4'd4, P_F, P_D, P_LK, P_JP, P_F}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode = 4'b0000;
    logic       wr_dst_rd, rf_we, alu_a_sel, mem_we, wb_from_mem, mem_addr_sel;
    logic       ir_load, pc_load, pc_load_if_zero, link_we;
    logic [1:0] alu_b_sel, pc_next_sel;
    logic [2:0] alu_fn;
    logic [16:0] act;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcyc_ctrl dut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .wr_dst_rd(wr_dst_rd), .rf_we(rf_we), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .alu_fn(alu_fn), .mem_we(mem_we),
        .wb_from_mem(wb_from_mem), .mem_addr_sel(mem_addr_sel),
        .ir_load(ir_load), .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
        .pc_next_sel(pc_next_sel), .link_we(link_we)
    );

    assign act = {wr_dst_rd, rf_we, alu_a_sel, alu_b_sel, alu_fn, mem_we,
                  wb_from_mem, mem_addr_sel, ir_load, pc_load, pc_load_if_zero,
                  pc_next_sel, link_we};

    // Expected output word of one step, from the requirements.
    function automatic logic [16:0] exp_word(input logic [3:0] p, input logic [3:0] op);
        logic dst = 0, we = 0, a = 0, mw = 0, wbm = 0, ad = 0, ir = 0, pl = 0, pz = 0, lk = 0;
        logic [1:0] b = 0, ps = 0;
        logic [2:0] fn = 0;
        case (p)
            P_F:  begin b = 2'b01; ir = 1; pl = 1; end
            P_D:  b = 2'b10;
            P_A:  begin a = 1; b = 2'b10; end
            P_MR: ad = 1;
            P_LW: begin we = 1; wbm = 1; end
            P_MW: begin ad = 1; mw = 1; end
            P_RX: begin a = 1; fn = op[2:0]; end
            P_RW: begin dst = 1; we = 1; end
            P_IX: begin a = 1; b = 2'b10; fn = op[2:0]; end
            P_IW: we = 1;
            P_BR: begin a = 1; fn = 3'b011; pz = 1; ps = 2'b01; end
            P_JP: begin pl = 1; ps = 2'b10; end
            P_LK: begin we = 1; lk = 1; end
            default: ;
        endcase
        return {dst, we, a, b, fn, mw, wbm, ad, ir, pl, pz, ps, lk};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'b0110: return "R3";
            4'b0111: return "R4";
            4'b1000, 4'b1001, 4'b1010: return "R6";
            4'b1011: return "R7";
            4'b1101: return "R8";
            4'b1111: return "R9";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input logic [16:0] exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %05h expected %05h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(exp_word(P_F, 4'b0), "R1", "fetch word during reset");
        rst = 1'b0;
        chk(exp_word(P_F, 4'b0), "R1", "fetch word after reset release");

        // Table walk: every non-halt opcode, back to back.
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0] op;
            int n;
            op = VEC[v][27:24];
            n  = int'(VEC[v][23:20]);
            opcode = op;
            for (int k = 0; k < n; k++) begin
                logic [3:0] p;
                p = VEC[v][19-4*k -: 4];
                chk(exp_word(p, op), (k == 0) ? "R1" : (k == 1) ? "R2" : tag_of(op),
                    $sformatf("op %b step %0d", op, k));
                @(negedge clk);
            end
        end
        // R11: the last path must be back in fetch.
        chk(exp_word(P_F, 4'b0), "R11", "return to fetch after last path");

        // R1: reset during the address step of a load.
        opcode = 4'b0110;
        @(negedge clk);
        @(negedge clk);
        chk(exp_word(P_A, 4'b0110), "R3", "address step before reset");
        rst = 1'b1;
        @(negedge clk);
        chk(exp_word(P_F, 4'b0), "R1", "mid-instruction reset to fetch");
        rst = 1'b0;
        @(negedge clk);
        chk(exp_word(P_D, 4'b0), "R1", "decode after mid reset");
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);

        // R10: halt parks with all outputs low, whatever the opcode does.
        chk(exp_word(P_F, 4'b0), "R10", "fetch before halt");
        opcode = 4'b1100;
        @(negedge clk);
        chk(exp_word(P_D, 4'b0), "R10", "decode of halt");
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            opcode = 4'(i);
            @(negedge clk);
            chk(17'h0, "R10", $sformatf("parked with opcode %0d", i));
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(exp_word(P_F, 4'b0), "R10", "reset leaves halt");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule